// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Update

This block is the arithmetic and logic core of a small 8-bit processor datapath. One operand pair and an operation code go in, the combinational result and a destination write strobe come out in the same cycle. A six-bit status register sits beside the datapath and is loaded at the clock edge when the operation is executed. The carry bit of that register feeds back into the carry-using operations, so multi-byte additions, subtractions and compares can be chained one byte per cycle.

Every operation has its own fixed rule for which status bits it rewrites and which it keeps. Some keep carry, one forces carry to one, compares compute a difference but suppress the destination write, and the compare-for-skip form leaves every status bit untouched and drives a skip output instead. Decode of the instruction word, the register file and branching live outside. The pins are plain control and status pins: an operation is offered and consumed in one cycle with no back-pressure, because the status register must be current for the next instruction.

Top module: `byte_alu`

## Requirements
- R1: While rst_n is low the status register clears to 0. The status bits are packed as flags[0]=carry C, [1]=zero Z, [2]=negative N, [3]=overflow V, [4]=sign S, [5]=half-carry H. With exec low, wr_en and skip are 0.
- R2: Add (op 0) gives a+b, add with carry (op 1) gives a+b+C; C is the carry out of bit 7, H the carry out of bit 3, V signed overflow, N result bit 7, Z set on a 0x00 result, S = N xor V; all six bits are rewritten and wr_en is 1.
- R3: Subtract (op 2) gives a-b, subtract with carry (op 3) gives a-b-C; C is the borrow out of bit 7, H the borrow out of bit 3, V signed overflow, N, S as in R2; all six bits are rewritten and wr_en is 1.
- R4: For subtract with carry (op 3) and compare with carry (op 5), Z becomes 0 on a nonzero result and keeps its old value on a zero result.
- R5: Compare (op 4) and compare with carry (op 5) set the status bits exactly as op 2 and op 3 do, with wr_en 0.
- R6: Compare-for-skip (op 6) drives skip to 1 exactly when a equals b, keeps all six status bits and drives wr_en 0.
- R7: Negate (op 7) gives 0-a (0x01 to 0xFF, 0xFF to 0x01, 0x00 to 0x00, 0x80 to 0x80); C is 1 unless the result is 0, H is 1 when a[3:0] is nonzero, V is 1 only for result 0x80; all six bits rewritten.
- R8: Complement (op 8) gives the bitwise inverse of a, forces C to 1, clears V, updates Z, N, S and keeps H.
- R9: Increment (op 9) gives a+1 with V=1 only for a=0x7F; decrement (op 10) gives a-1 with V=1 only for a=0x80; both update Z, N, S and keep C and H.
- R10: AND (op 11) gives a&b, clearing every bit outside b; OR (op 12) gives a|b, keeping every bit of a where b is 0; both clear V, update Z, N, S and keep C and H.
- R11: Move (op 13) gives b, nibble swap (op 14) gives {a[3:0],a[7:4]} (0xFA to 0xAF); both write and keep all six status bits.
- R12: Rotate left (op 15) gives {a[6:0],C}, shift left (op 16) gives {a[6:0],0}, both with new C=a[7]; rotate right (op 17) gives {C,a[7:1]}, shift right (op 18) gives {0,a[7:1]}, both with new C=a[0]; all four set V = N xor new C, update Z, N, S and keep H.
- R13: The status register loads flags_nxt at the rising edge when exec is 1 and holds otherwise; flags_nxt equals flags when exec is 0. Op codes 19 to 31 neither write nor change any status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low synchronous reset |
| exec | input | 1 | The offered operation executes this cycle |
| op | input | 5 | Operation code |
| opnd_a | input | 8 | Destination operand |
| opnd_b | input | 8 | Source operand |
| result | output | 8 | Combinational result |
| wr_en | output | 1 | Write strobe for the destination register |
| skip | output | 1 | Skip-next-instruction condition from compare-for-skip |
| flags_nxt | output | 6 | Value the status register takes at the next edge |
| flags | output | 6 | Current status register |

## Verification
Directed patterns target the boundaries that separate the status rules: 0x7F+1 and 0x80-1 for signed overflow, 0xFF+1 for carry, zero and half-carry together, nibble borrows, and the four negate corner values. A two-byte subtract-with-carry chain with equal and unequal high bytes tells a sticky zero apart from a freshly computed one, and increment, complement and logic operations run after both carry values show whether carry is kept or forced. Rotates and shifts run with carry set and clear to tell them apart, and a long random sequence including unused codes and idle cycles is compared every cycle against a behavioural model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CPC  = 5'd5,
    OP_CPSE = 5'd6,
    OP_NEG  = 5'd7,
    OP_COM  = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_AND  = 5'd11,
    OP_OR   = 5'd12,
    OP_MOV  = 5'd13,
    OP_SWAP = 5'd14,
    OP_ROL  = 5'd15,
    OP_LSL  = 5'd16,
    OP_ROR  = 5'd17,
    OP_LSR  = 5'd18
  } alu_op_e;

  localparam int OP_W   = 5;
  localparam int FLAG_W = 6;

  // bit 0 = carry ... bit 5 = half-carry
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flag_t;

  typedef enum logic [1:0] {
    Y_B   = 2'd0,
    Y_ONE = 2'd1,
    Y_A   = 2'd2
  } ysel_e;

  typedef struct packed {
    logic  sub;
    logic  x_zero;
    ysel_e y_sel;
    logic  cin_en;
    logic  use_bitop;
    logic  wr;
    logic  skip_chk;
    logic  upd_c;
    logic  upd_z;
    logic  upd_nvs;
    logic  upd_h;
    logic  z_sticky;
  } ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.y_sel = Y_B;
    case (op)
      OP_ADD, OP_ADC: begin
        ctrl.cin_en  = (op == OP_ADC);
        ctrl.wr      = 1'b1;
        ctrl.upd_c   = 1'b1;
        ctrl.upd_z   = 1'b1;
        ctrl.upd_nvs = 1'b1;
        ctrl.upd_h   = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CPC: begin
        ctrl.sub      = 1'b1;
        ctrl.cin_en   = (op == OP_SBC) || (op == OP_CPC);
        ctrl.z_sticky = (op == OP_SBC) || (op == OP_CPC);
        ctrl.wr       = (op == OP_SUB) || (op == OP_SBC);
        ctrl.upd_c    = 1'b1;
        ctrl.upd_z    = 1'b1;
        ctrl.upd_nvs  = 1'b1;
        ctrl.upd_h    = 1'b1;
      end
      OP_CPSE: begin
        ctrl.sub      = 1'b1;
        ctrl.skip_chk = 1'b1;
      end
      OP_NEG: begin
        ctrl.sub     = 1'b1;
        ctrl.x_zero  = 1'b1;
        ctrl.y_sel   = Y_A;
        ctrl.wr      = 1'b1;
        ctrl.upd_c   = 1'b1;
        ctrl.upd_z   = 1'b1;
        ctrl.upd_nvs = 1'b1;
        ctrl.upd_h   = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctrl.sub     = (op == OP_DEC);
        ctrl.y_sel   = Y_ONE;
        ctrl.wr      = 1'b1;
        ctrl.upd_z   = 1'b1;
        ctrl.upd_nvs = 1'b1;
      end
      OP_COM, OP_ROL, OP_LSL, OP_ROR, OP_LSR: begin
        ctrl.use_bitop = 1'b1;
        ctrl.wr        = 1'b1;
        ctrl.upd_c     = 1'b1;
        ctrl.upd_z     = 1'b1;
        ctrl.upd_nvs   = 1'b1;
      end
      OP_AND, OP_OR: begin
        ctrl.use_bitop = 1'b1;
        ctrl.wr        = 1'b1;
        ctrl.upd_z     = 1'b1;
        ctrl.upd_nvs   = 1'b1;
      end
      OP_MOV, OP_SWAP: begin
        ctrl.use_bitop = 1'b1;
        ctrl.wr        = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic         sub,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         cout,
  output logic         hout,
  output logic         vout
);

  localparam int HALF = W / 2;

  logic [W:0]    full;
  logic [HALF:0] low;
  logic [W:0]    cin_w;
  logic [HALF:0] cin_h;

  assign cin_w = {{W{1'b0}}, cin};
  assign cin_h = {{HALF{1'b0}}, cin};

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - cin_w;
      low  = {1'b0, x[HALF-1:0]} - {1'b0, y[HALF-1:0]} - cin_h;
    end else begin
      full = {1'b0, x} + {1'b0, y} + cin_w;
      low  = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + cin_h;
    end
  end

  assign r    = full[W-1:0];
  assign cout = full[W];
  assign hout = low[HALF];

  always_comb begin
    if (sub)
      vout = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
    else
      vout = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
  end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  output logic [W-1:0]    r,
  output logic            cout,
  output logic            vout
);

  localparam int HALF = W / 2;

  logic is_shift;

  always_comb begin
    r        = '0;
    cout     = cin;
    is_shift = 1'b0;
    case (op)
      OP_COM:  begin r = ~a; cout = 1'b1; end
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_MOV:  r = b;
      OP_SWAP: r = {a[HALF-1:0], a[W-1:HALF]};
      OP_ROL:  begin r = {a[W-2:0], cin};  cout = a[W-1]; is_shift = 1'b1; end
      OP_LSL:  begin r = {a[W-2:0], 1'b0}; cout = a[W-1]; is_shift = 1'b1; end
      OP_ROR:  begin r = {cin, a[W-1:1]};  cout = a[0];   is_shift = 1'b1; end
      OP_LSR:  begin r = {1'b0, a[W-1:1]}; cout = a[0];   is_shift = 1'b1; end
      default: ;
    endcase
    vout = is_shift ? (r[W-1] ^ cout) : 1'b0;
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  logic [OP_W-1:0]   op,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  output logic [W-1:0]      result,
  output logic              wr_en,
  output logic              skip,
  output logic [FLAG_W-1:0] flags_nxt,
  output logic [FLAG_W-1:0] flags
);

  ctrl_t        ctrl;
  flag_t        cur;
  flag_t        upd;
  flag_t        nxt;
  logic [W-1:0] x_in;
  logic [W-1:0] y_in;
  logic         cin;
  logic [W-1:0] as_r;
  logic         as_c;
  logic         as_h;
  logic         as_v;
  logic [W-1:0] bo_r;
  logic         bo_c;
  logic         bo_v;
  logic         raw_c;
  logic         raw_v;
  logic         res_zero;

  alu_decode u_dec (
    .op   (op),
    .ctrl (ctrl)
  );

  assign x_in = ctrl.x_zero ? '0 : opnd_a;

  always_comb begin
    case (ctrl.y_sel)
      Y_ONE:   y_in = {{(W-1){1'b0}}, 1'b1};
      Y_A:     y_in = opnd_a;
      default: y_in = opnd_b;
    endcase
  end

  assign cin = ctrl.cin_en & cur.c;

  alu_addsub #(.W(W)) u_as (
    .sub  (ctrl.sub),
    .x    (x_in),
    .y    (y_in),
    .cin  (cin),
    .r    (as_r),
    .cout (as_c),
    .hout (as_h),
    .vout (as_v)
  );

  alu_bitops #(.W(W)) u_bo (
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .cin  (cur.c),
    .r    (bo_r),
    .cout (bo_c),
    .vout (bo_v)
  );

  assign result   = ctrl.use_bitop ? bo_r : as_r;
  assign raw_c    = ctrl.use_bitop ? bo_c : as_c;
  assign raw_v    = ctrl.use_bitop ? bo_v : as_v;
  assign res_zero = (result == '0);

  always_comb begin
    upd   = cur;
    upd.c = ctrl.upd_c ? raw_c : cur.c;
    if (ctrl.upd_z)
      upd.z = ctrl.z_sticky ? (res_zero & cur.z) : res_zero;
    if (ctrl.upd_nvs) begin
      upd.n = result[W-1];
      upd.v = raw_v;
      upd.s = result[W-1] ^ raw_v;
    end
    upd.h = ctrl.upd_h ? as_h : cur.h;
  end

  assign nxt = exec ? upd : cur;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur <= '0;
    else
      cur <= nxt;
  end

  assign flags     = cur;
  assign flags_nxt = nxt;
  assign wr_en     = exec & ctrl.wr;
  assign skip      = exec & ctrl.skip_chk & (as_r == '0);

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec,
  input logic [OP_W-1:0]   op,
  input logic [W-1:0]      opnd_a,
  input logic [W-1:0]      opnd_b,
  input logic [W-1:0]      result,
  input logic              wr_en,
  input logic              skip,
  input logic [FLAG_W-1:0] flags
);

  assert_add_neg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_ADD) |=> flags[2] == $past(result[W-1]));

  assert_zero_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OP_SBC || op == OP_CPC) && result != '0) |=> !flags[1]);

  assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP || op == OP_CPC || op == OP_CPSE) |-> !wr_en);

  assert_skip_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (exec && op == OP_CPSE && opnd_a == opnd_b));

  assert_skip_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_CPSE) |=> flags == $past(flags));

  assert_com_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_COM) |=> flags[0]);

  assert_keep_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OP_INC || op == OP_DEC)) |=> flags[0] == $past(flags[0]));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> flags == $past(flags));

endmodule

bind byte_alu byte_alu_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .exec   (exec),
  .op     (op),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .result (result),
  .wr_en  (wr_en),
  .skip   (skip),
  .flags  (flags)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec;
  logic [4:0] op;
  logic [7:0] opnd_a;
  logic [7:0] opnd_b;
  logic [7:0] result;
  logic       wr_en;
  logic       skip;
  logic [5:0] flags_nxt;
  logic [5:0] flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model status bits
  int mc, mz, mn, mv, ms, mh;
  // expected outputs
  int er, ewr, eskip, ec, ez, en, ev, es, eh;

  always #5 clk = ~clk;

  byte_alu uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec      (exec),
    .op        (op),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .wr_en     (wr_en),
    .skip      (skip),
    .flags_nxt (flags_nxt),
    .flags     (flags)
  );

  function automatic string req_of(int o);
    case (o)
      0, 1:           return "R2";
      2:              return "R3";
      3:              return "R3,R4";
      4:              return "R5";
      5:              return "R5,R4";
      6:              return "R6";
      7:              return "R7";
      8:              return "R8";
      9, 10:          return "R9";
      11, 12:         return "R10";
      13, 14:         return "R11";
      15, 16, 17, 18: return "R12";
      default:        return "R13";
    endcase
  endfunction

  function automatic logic [5:0] pack(int c, int z, int n, int v, int s, int h);
    return {h[0], s[0], v[0], n[0], z[0], c[0]};
  endfunction

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic set_nzs();
    en = (er >> 7) & 1;
    ez = (er == 0);
    es = en ^ ev;
  endtask

  task automatic model(int o, int a, int b, int x);
    int d;
    int ci;
    ec = mc; ez = mz; en = mn; ev = mv; es = ms; eh = mh;
    er = 0; ewr = 0; eskip = 0;
    if (x == 0) return;
    case (o)
      0, 1: begin
        ci = (o == 1) ? mc : 0;
        d = a + b + ci;
        er = d & 255;
        ec = (d > 255);
        eh = ((a & 15) + (b & 15) + ci) > 15;
        ev = (((a ^ er) & (b ^ er) & 128) != 0);
        set_nzs();
        ewr = 1;
      end
      2, 3, 4, 5: begin
        ci = (o == 3 || o == 5) ? mc : 0;
        d = a - b - ci;
        er = d & 255;
        ec = (d < 0);
        eh = ((a & 15) - (b & 15) - ci) < 0;
        ev = (((a ^ b) & (a ^ er) & 128) != 0);
        set_nzs();
        if (o == 3 || o == 5) ez = (er == 0) ? mz : 0;
        ewr = (o == 2 || o == 3);
      end
      6: begin
        er = (a - b) & 255;
        eskip = (a == b);
      end
      7: begin
        er = (256 - a) & 255;
        ec = (er != 0);
        eh = ((a & 15) != 0);
        ev = (er == 128);
        set_nzs();
        ewr = 1;
      end
      8:  begin er = 255 - a; ec = 1; ev = 0; set_nzs(); ewr = 1; end
      9:  begin er = (a + 1) & 255; ev = (a == 127); set_nzs(); ewr = 1; end
      10: begin er = (a + 255) & 255; ev = (a == 128); set_nzs(); ewr = 1; end
      11: begin er = a & b; ev = 0; set_nzs(); ewr = 1; end
      12: begin er = a | b; ev = 0; set_nzs(); ewr = 1; end
      13: begin er = b; ewr = 1; end
      14: begin er = ((a & 15) << 4) | (a >> 4); ewr = 1; end
      15, 16, 17, 18: begin
        if (o == 15)      begin er = ((a << 1) & 255) | mc; ec = a >> 7; end
        else if (o == 16) begin er = (a << 1) & 255;        ec = a >> 7; end
        else if (o == 17) begin er = (mc << 7) | (a >> 1);  ec = a & 1; end
        else              begin er = a >> 1;                ec = a & 1; end
        en = er >> 7;
        ev = en ^ ec;
        set_nzs();
        ewr = 1;
      end
      default: ;
    endcase
  endtask

  task automatic step(int o, int a, int b, int x = 1);
    string rq;
    @(negedge clk);
    op = 5'(o); opnd_a = 8'(a); opnd_b = 8'(b); exec = x[0];
    model(o, a, b, x);
    rq = (x == 0) ? "R13" : req_of(o);
    #1;
    if (ewr != 0) check(rq, "result", int'(result), er);
    check(rq, "wr_en", int'(wr_en), ewr);
    check(rq, "skip", int'(skip), eskip);
    check(rq, "flags_nxt", int'(flags_nxt), int'(pack(ec, ez, en, ev, es, eh)));
    @(posedge clk);
    #1;
    check(rq, "flags", int'(flags), int'(pack(ec, ez, en, ev, es, eh)));
    mc = ec; mz = ez; mn = en; mv = ev; ms = es; mh = eh;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exec = 1'b0; op = '0; opnd_a = 8'h5A; opnd_b = 8'hA5;
    mc = 0; mz = 0; mn = 0; mv = 0; ms = 0; mh = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "flags after reset", int'(flags), 0);
    check("R1", "wr_en idle", int'(wr_en), 0);
    check("R1", "skip idle", int'(skip), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 add boundaries
    step(0, 8'h7F, 8'h01);
    step(0, 8'hFF, 8'h01);
    step(1, 8'h00, 8'h00);           // carry chained in
    step(1, 8'h0F, 8'h00);
    // R3 / R4 subtract and sticky zero
    step(2, 8'h00, 8'h01);
    step(2, 8'h80, 8'h01);
    step(2, 8'h10, 8'h10);           // Z=1, C=0
    step(3, 8'h22, 8'h22);           // zero result keeps Z=1
    step(2, 8'h10, 8'h20);           // Z=0, C=1
    step(3, 8'h21, 8'h20);           // zero result keeps Z=0
    step(3, 8'h05, 8'h02);           // nonzero clears Z
    // R5 compares
    step(4, 8'h33, 8'h33);
    step(5, 8'h40, 8'h41);
    step(4, 8'h01, 8'h02);
    // R6 compare-for-skip
    step(6, 8'h5C, 8'h5C);
    step(6, 8'h5C, 8'h5D);
    // R7 negate corners
    step(7, 8'h01, 0);
    step(7, 8'hFF, 0);
    step(7, 8'h00, 0);
    step(7, 8'h80, 0);
    // R8 complement after carry clear
    step(7, 8'h00, 0);
    step(8, 8'h0F, 0);
    // R9 inc/dec keep carry (set and clear)
    step(9, 8'h7F, 0);
    step(9, 8'hFF, 0);
    step(2, 8'h05, 8'h01);           // C=0
    step(10, 8'h80, 0);
    step(10, 8'h00, 0);
    // R10 masks
    step(11, 8'hB7, 8'h0F);
    step(12, 8'hA0, 8'h05);
    step(11, 8'hF0, 8'h0F);
    // R11 move / swap
    step(13, 8'h12, 8'h9C);
    step(14, 8'hFA, 0);
    // R12 shifts with both carry values
    step(8, 8'h00, 0);               // C=1
    step(15, 8'h40, 0);
    step(17, 8'h02, 0);
    step(16, 8'h81, 0);
    step(18, 8'h01, 0);
    step(17, 8'h80, 0);
    step(15, 8'h80, 0);
    // R13 idle and unused codes
    step(0, 8'hFF, 8'hFF, 0);
    step(19, 8'hFF, 8'h01);
    step(31, 8'h00, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      int o;
      int x;
      o = $urandom_range(0, 21);
      x = ($urandom_range(0, 7) != 0) ? 1 : 0;
      step(o, $urandom_range(0, 255), $urandom_range(0, 255), x);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule